// File: doc/BRIEF.md
# Width-Adapting Memory-to-Memory DMA Channel

This block is one DMA channel that copies data between two memory regions whose access widths may differ. Either side can use byte, halfword or word accesses. The channel reads as many source beats as one destination beat needs. It packs those beats little-endian into a staging register, then writes the staged bytes out as one or more destination beats. A group of reads followed by writes repeats until the remaining count, which is held in source-width units, reaches zero.

A 32-bit control word configures the transfer, together with a start source address and a start destination address. The control word is loaded with `cfg_we` while the channel is idle. Setting the enable bit starts the transfer. The control word, source address and destination address stay visible at the outputs throughout the transfer. A one-cycle `done` pulse marks normal completion. A one-cycle `err` pulse marks a rejected configuration. In both cases the enable bit is cleared. Memory accesses use a simple request interface. Each request is a single-cycle pulse. Read data, right-aligned, is returned on the clock edge after the request.

Top module: `dma_wx_engine`

## Requirements
- R1: The count field holds the remaining transfer length in source-width units. Each group lowers it by max(swidth,dwidth)/swidth. When the count reaches zero, `done` pulses for one cycle and the count field reads 0.
- R2: Each group issues max(swidth,dwidth)/swidth source reads, so a whole transfer makes exactly `count` reads. With source increment set, the source address advances by the source width after every read. With it clear, the source address stays fixed.
- R3: Each group issues max(swidth,dwidth)/dwidth destination writes, so a whole transfer makes count*swidth/dwidth writes. Each write goes to the current destination address. With destination increment set, that address then advances by the destination width; with it clear, it stays fixed.
- R4: Source beats fill the staging register from byte lane 0 upward, little-endian. Reading bytes 0x11, 0x22, 0x33, 0x44 at byte width and writing at word width stores the word 0x44332211 at the destination.
- R5: If count*swidth is not a multiple of dwidth, the channel makes no memory access, pulses `err` and leaves the count unchanged.
- R6: Width codes are 0 = byte, 1 = halfword and 2 = word. A width code of 3 in either field causes an `err` pulse with no memory access.
- R7: Control word layout:
  - count in bits [11:0]
  - source width code in bits [13:12]
  - destination width code in bits [15:14]
  - source increment in bit 16
  - destination increment in bit 17
  - enable in bit 31

  The channel writes back only bits [11:0] and clears bit 31 on completion or error. Bits [30:12] keep their loaded value.
- R8: An enabled start with count 0 finishes with a `done` pulse and makes no memory access.
- R9: A configuration write while the channel is busy is ignored. The running transfer completes as configured.
- R10: After reset, the control word, `busy`, `mem_req`, `done` and `err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load control word and addresses (idle only) |
| cfg_ctrl | input | 32 | Control word to load |
| cfg_src | input | AW | Start source address |
| cfg_dst | input | AW | Start destination address |
| ctrl_out | output | 32 | Current control word |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| busy | output | 1 | Channel is running |
| mem_req | output | 1 | Memory access request (one-cycle pulse) |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the access |
| mem_size | output | 2 | Width code of the access |
| mem_wdata | output | DATA_W | Write data, right-aligned |
| mem_rdata | input | DATA_W | Read data, right-aligned, valid one edge after the request |
| done | output | 1 | Transfer complete pulse |
| err | output | 1 | Configuration rejected pulse |

## Verification
The bench drives every pairing of source and destination widths, in both increment states, and compares the memory image against a byte-level reference model.

**Count and addressing faults**
- A design that lowered the count by one per group would issue too many reads and overrun the source region.
- A design that offset each write beyond the current destination address, or stepped the destination by the source width, would scatter bytes. The memory compare exposes both.

**Rejected configurations**
- Counts that cannot fill a final destination beat must produce an error with zero accesses. A lenient design would instead perform a partial last write.
- Illegal width codes must likewise produce an error with zero accesses.
- A zero count must complete at once with no accesses.

**Packing and busy writes**
- The byte-to-word case checks lane order.
- A configuration written mid-transfer must leave the running transfer unchanged.

// File: rtl/dma_wx_pkg.sv
package dma_wx_pkg;
  localparam int CTRL_W   = 32;
  localparam int CNT_W    = 12;
  localparam int POS_SW   = 12;
  localparam int POS_DW   = 14;
  localparam int POS_SINC = 16;
  localparam int POS_DINC = 17;
  localparam int POS_EN   = 31;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_RD, S_RSENT, S_RCAP, S_WR, S_WSENT
  } wx_state_t;
endpackage

// File: rtl/dma_wx_width_dec.sv
module dma_wx_width_dec (
  input  logic [1:0] code,
  output logic       legal,
  output logic [2:0] nbytes
);
  always_comb begin
    legal  = (code != 2'd3);
    nbytes = legal ? (3'd1 << code) : 3'd0;
  end
endmodule

// File: rtl/dma_wx_rule.sv
module dma_wx_rule #(
  parameter int CNT_W = 12
) (
  input  logic [1:0]       scode,
  input  logic [1:0]       dcode,
  input  logic [CNT_W-1:0] count,
  output logic             fits,
  output logic [2:0]       rd_beats,
  output logic [2:0]       wr_beats
);
  logic [1:0]       gap;
  logic [CNT_W-1:0] low_mask;

  always_comb begin
    gap      = (dcode > scode) ? (dcode - scode) : (scode - dcode);
    low_mask = CNT_W'((1 << gap) - 1);
    if (dcode > scode) begin
      rd_beats = 3'(1 << gap);
      wr_beats = 3'd1;
      fits     = ((count & low_mask) == '0);
    end else begin
      rd_beats = 3'd1;
      wr_beats = 3'(1 << gap);
      fits     = 1'b1;
    end
  end
endmodule

// File: rtl/dma_wx_stage.sv
module dma_wx_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_off,
  input  logic [2:0]        wr_nb,
  input  logic [DATA_W-1:0] din,
  input  logic [2:0]        rd_off,
  input  logic [2:0]        rd_nb,
  output logic [DATA_W-1:0] dout
);
  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0] buf_q;
  logic [DATA_W-1:0] din_sh;
  logic [NB-1:0]     lane_en;
  logic [DATA_W-1:0] rd_mask;

  always_comb begin
    din_sh  = din << (int'(wr_off) * 8);
    lane_en = NB'(((1 << wr_nb) - 1) << wr_off);
    rd_mask = DATA_W'((64'd1 << (int'(rd_nb) * 8)) - 64'd1);
    dout    = (buf_q >> (int'(rd_off) * 8)) & rd_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < NB; b++)
        if (lane_en[b]) buf_q[b*8 +: 8] <= din_sh[b*8 +: 8];
    end
  end

  AST_LANES_FIT: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_off) + int'(wr_nb) <= NB)); // R4
endmodule

// File: rtl/dma_wx_engine.sv
module dma_wx_engine
  import dma_wx_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_ctrl,
  input  logic [AW-1:0]     cfg_src,
  input  logic [AW-1:0]     cfg_dst,
  output logic [CTRL_W-1:0] ctrl_out,
  output logic [AW-1:0]     src_addr,
  output logic [AW-1:0]     dst_addr,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              err
);
  wx_state_t         state;
  logic [CTRL_W-1:0] ctrl_q;
  logic [AW-1:0]     src_q, dst_q;
  logic [2:0]        rd_idx, wr_idx;

  logic [1:0]        scode, dcode;
  logic              s_ok, d_ok, fits;
  logic [2:0]        sw_nb, dw_nb, rd_beats, wr_beats;
  logic [CNT_W-1:0]  cnt, cnt_next;
  logic [DATA_W-1:0] stage_out;
  logic              sinc, dinc;

  assign scode    = ctrl_q[POS_SW +: 2];
  assign dcode    = ctrl_q[POS_DW +: 2];
  assign sinc     = ctrl_q[POS_SINC];
  assign dinc     = ctrl_q[POS_DINC];
  assign cnt      = ctrl_q[CNT_W-1:0];
  assign cnt_next = cnt - CNT_W'(rd_beats);

  dma_wx_width_dec u_sdec (.code(scode), .legal(s_ok), .nbytes(sw_nb));
  dma_wx_width_dec u_ddec (.code(dcode), .legal(d_ok), .nbytes(dw_nb));

  dma_wx_rule #(.CNT_W(CNT_W)) u_rule (
    .scode(scode), .dcode(dcode), .count(cnt),
    .fits(fits), .rd_beats(rd_beats), .wr_beats(wr_beats)
  );

  dma_wx_stage #(.DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst(rst),
    .wr_en(state == S_RCAP),
    .wr_off(3'(rd_idx << scode)), .wr_nb(sw_nb), .din(mem_rdata),
    .rd_off(3'(wr_idx << dcode)), .rd_nb(dw_nb), .dout(stage_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      ctrl_q    <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      rd_idx    <= '0;
      wr_idx    <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_size  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        S_IDLE: if (cfg_we) begin
          ctrl_q <= cfg_ctrl;
          src_q  <= cfg_src;
          dst_q  <= cfg_dst;
          if (cfg_ctrl[POS_EN]) state <= S_CHECK;
        end
        S_CHECK: begin
          rd_idx <= '0;
          wr_idx <= '0;
          if (!s_ok || !d_ok || !fits) begin
            err            <= 1'b1;
            ctrl_q[POS_EN] <= 1'b0;
            state          <= S_IDLE;
          end else if (cnt == '0) begin
            done           <= 1'b1;
            ctrl_q[POS_EN] <= 1'b0;
            state          <= S_IDLE;
          end else begin
            state <= S_RD;
          end
        end
        S_RD: begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= src_q;
          mem_size <= scode;
          if (sinc) src_q <= src_q + AW'(sw_nb);
          state    <= S_RSENT;
        end
        S_RSENT: begin
          mem_req <= 1'b0;
          state   <= S_RCAP;
        end
        S_RCAP: begin
          if (rd_idx + 3'd1 == rd_beats) begin
            rd_idx <= '0;
            wr_idx <= '0;
            state  <= S_WR;
          end else begin
            rd_idx <= rd_idx + 3'd1;
            state  <= S_RD;
          end
        end
        S_WR: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= dst_q;
          mem_size  <= dcode;
          mem_wdata <= stage_out;
          if (dinc) dst_q <= dst_q + AW'(dw_nb);
          state     <= S_WSENT;
        end
        S_WSENT: begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          if (wr_idx + 3'd1 == wr_beats) begin
            wr_idx              <= '0;
            ctrl_q[CNT_W-1:0]   <= cnt_next;
            if (cnt_next == '0) begin
              done           <= 1'b1;
              ctrl_q[POS_EN] <= 1'b0;
              state          <= S_IDLE;
            end else begin
              state <= S_RD;
            end
          end else begin
            wr_idx <= wr_idx + 3'd1;
            state  <= S_WR;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ctrl_out = ctrl_q;
  assign src_addr = src_q;
  assign dst_addr = dst_q;
  assign busy     = (state != S_IDLE);

  AST_WRITE_IS_REQ: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req); // R3
  AST_SRC_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && sinc) |-> (src_q == mem_addr + AW'(sw_nb))); // R2
  AST_SRC_FIXED: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && !sinc) |-> (src_q == mem_addr)); // R2
  AST_DST_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && dinc) |-> (dst_q == mem_addr + AW'(dw_nb))); // R3
  AST_DONE_ZERO: assert property (@(posedge clk) disable iff (rst)
    done |-> (ctrl_q[CNT_W-1:0] == '0 && !ctrl_q[POS_EN])); // R1
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    err |-> (!mem_req && !done && !ctrl_q[POS_EN])); // R5
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (ctrl_q[POS_EN-1:POS_SW] == $past(ctrl_q[POS_EN-1:POS_SW]))); // R7
endmodule

// File: tb/tb_dma_wx_engine.sv
`timescale 1ns/1ps
module tb_dma_wx_engine;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_we;
  logic [31:0]   cfg_ctrl;
  logic [AW-1:0] cfg_src, cfg_dst;
  logic [31:0]   ctrl_out;
  logic [AW-1:0] src_addr, dst_addr, mem_addr;
  logic          busy, mem_req, mem_we, done, err;
  logic [1:0]    mem_size;
  logic [DW-1:0] mem_wdata, mem_rdata;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  dma_wx_engine #(.AW(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ctrl(cfg_ctrl),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .ctrl_out(ctrl_out),
    .src_addr(src_addr), .dst_addr(dst_addr), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .err(err)
  );

  // Byte memory model, one-edge read latency
  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  logic       reload = 1'b0;
  int         reload_mode = 0;
  int         reload_seed = 0;
  int         n_rd = 0;
  int         n_wr = 0;

  function automatic logic [7:0] pat(int mode, int seed, int i);
    if (mode == 1) return (i < 4) ? 8'((i + 1) * 17) : 8'h00;
    return 8'((i * 37) ^ (seed * 11) ^ 5);
  endfunction

  always @(posedge clk) begin
    if (reload) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(reload_mode, reload_seed, i);
    end else if (mem_req && !mem_we) begin
      mem_rdata <= {mem[8'(mem_addr + 3)], mem[8'(mem_addr + 2)],
                    mem[8'(mem_addr + 1)], mem[8'(mem_addr)]};
      n_rd <= n_rd + 1;
    end else if (mem_req && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (b < (1 << mem_size)) mem[8'(mem_addr + 32'(b))] <= mem_wdata[b*8 +: 8];
      n_wr <= n_wr + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic load_mem(input int mode, input int seed);
    @(negedge clk);
    reload_mode = mode; reload_seed = seed; reload = 1'b1;
    @(negedge clk);
    reload = 1'b0;
    for (int i = 0; i < 256; i++) ref_mem[i] = pat(mode, seed, i);
  endtask

  // Byte-level reference of a legal transfer
  task automatic ref_xfer(input int sw, input int dw, input int cnt, input bit si, input bit di,
                          input int s0, input int d0, output int s_end, output int d_end);
    int sb, db, xs, groups, s, d;
    logic [7:0] stg [4];
    sb = 1 << sw; db = 1 << dw; xs = (sb > db) ? sb : db;
    groups = cnt * sb / xs; s = s0; d = d0;
    for (int g = 0; g < groups; g++) begin
      for (int r = 0; r < xs / sb; r++) begin
        for (int b = 0; b < sb; b++) stg[r*sb + b] = ref_mem[(s + b) & 255];
        if (si) s += sb;
      end
      for (int w = 0; w < xs / db; w++) begin
        for (int b = 0; b < db; b++) ref_mem[(d + b) & 255] = stg[w*db + b];
        if (di) d += db;
      end
    end
    s_end = s; d_end = d;
  endtask

  function automatic logic [31:0] mk_ctrl(int cnt, int sw, int dw, bit si, bit di, logic [12:0] upper);
    return {1'b1, upper, di, si, 2'(dw), 2'(sw), 12'(cnt)};
  endfunction

  task automatic run(input logic [31:0] c, input int s, input int d, input bit poke,
                     output bit got_done, output bit got_err, output int rds, output int wrs);
    int r0, w0;
    r0 = n_rd; w0 = n_wr;
    got_done = 0; got_err = 0;
    @(negedge clk);
    cfg_ctrl = c; cfg_src = s; cfg_dst = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    if (poke) begin
      @(negedge clk);
      cfg_ctrl = 32'h8000_5003; cfg_src = 32'h40; cfg_dst = 32'hF0; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
    end
    for (int i = 0; i < 4000; i++) begin
      if (done || err) begin
        got_done = done; got_err = err;
        break;
      end
      @(negedge clk);
    end
    rds = n_rd - r0; wrs = n_wr - w0;
    chk(got_done || got_err, "R1 transfer ended", 32'(busy), 0);
  endtask

  task automatic mem_cmp(input string tag);
    int bad;
    bad = -1;
    for (int i = 0; i < 256; i++) if (bad < 0 && mem[i] !== ref_mem[i]) bad = i;
    chk(bad < 0, tag, (bad < 0) ? 0 : {bad[15:0], 8'h0, mem[bad]},
        (bad < 0) ? 0 : {bad[15:0], 8'h0, ref_mem[bad]});
  endtask

  task automatic legal_case(input int sw, input int dw, input int cnt, input bit si, input bit di,
                            input int s, input int d, input logic [12:0] up, input bit poke);
    bit gd, ge; int rds, wrs, se, de;
    logic [31:0] c;
    c = mk_ctrl(cnt, sw, dw, si, di, up);
    ref_xfer(sw, dw, cnt, si, di, s, d, se, de);
    run(c, s, d, poke, gd, ge, rds, wrs);
    chk(gd && !ge, "R1 done pulse", {gd, ge}, 2);
    chk(ctrl_out == {1'b0, c[30:12], 12'h0}, "R7 final control word", ctrl_out, {1'b0, c[30:12], 12'h0});
    chk(rds == cnt, "R2 read count", rds, cnt);
    chk(wrs == cnt * (1 << sw) / (1 << dw), "R3 write count", wrs, cnt * (1 << sw) / (1 << dw));
    chk(src_addr == 32'(se), "R2 final source address", src_addr, se);
    chk(dst_addr == 32'(de), "R3 final destination address", dst_addr, de);
    mem_cmp(poke ? "R9 memory after busy write" : "R3 memory image");
  endtask

  task automatic bad_case(input logic [31:0] c, input string tag);
    bit gd, ge; int rds, wrs;
    run(c, 8, 160, 1'b0, gd, ge, rds, wrs);
    chk(ge && !gd, {tag, " error pulse"}, {gd, ge}, 1);
    chk(rds == 0 && wrs == 0, {tag, " no access"}, rds + wrs, 0);
    chk(ctrl_out == {1'b0, c[30:0]}, {tag, " control kept"}, ctrl_out, {1'b0, c[30:0]});
    mem_cmp({tag, " memory untouched"});
  endtask

  initial begin
    #400000;
    n_fails++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 1, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    bit gd, ge; int rds, wrs;
    void'($urandom(32'd7321));
    rst = 1'b1; cfg_we = 1'b0; cfg_ctrl = '0; cfg_src = '0; cfg_dst = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk(ctrl_out == 0 && !busy && !mem_req && !done && !err, "R10 reset state",
        {ctrl_out[31:4], busy, mem_req, done, err}, 0);

    // R4 byte to word packing
    load_mem(1, 0);
    legal_case(0, 2, 4, 1, 1, 0, 32'h80, 13'h0, 0);
    chk({mem[8'h83], mem[8'h82], mem[8'h81], mem[8'h80]} == 32'h44332211, "R4 packed word",
        {mem[8'h83], mem[8'h82], mem[8'h81], mem[8'h80]}, 32'h44332211);

    // Directed: word to byte, halfword to word, fixed addresses
    load_mem(0, 3);
    legal_case(2, 0, 3, 1, 1, 4, 32'h90, 13'h1A5, 0);
    load_mem(0, 4);
    legal_case(1, 2, 6, 1, 0, 2, 32'hA1, 13'h0F0, 0);
    load_mem(0, 5);
    legal_case(0, 1, 8, 0, 1, 9, 32'h88, 13'h001, 0);

    // R5 count that cannot fill a destination beat
    load_mem(0, 6);
    bad_case(mk_ctrl(5, 0, 2, 1, 1, 13'h055), "R5");
    bad_case(mk_ctrl(3, 0, 1, 1, 1, 13'h000), "R5");
    // R6 illegal width codes
    bad_case(mk_ctrl(4, 3, 0, 1, 1, 13'h000), "R6");
    bad_case(mk_ctrl(4, 1, 3, 1, 1, 13'h1FF), "R6");

    // R8 zero count
    run(mk_ctrl(0, 1, 2, 1, 1, 13'h0), 4, 32'h90, 1'b0, gd, ge, rds, wrs);
    chk(gd && !ge && rds == 0 && wrs == 0, "R8 zero count", {gd, ge, 6'(rds + wrs)}, 8'h80);

    // R9 configuration write while busy
    load_mem(0, 8);
    legal_case(0, 2, 8, 1, 1, 16, 32'h84, 13'h033, 1);

    // Random mix
    for (int t = 0; t < 40; t++) begin
      int sw, dw, cnt, ratio;
      bit si, di;
      sw = $urandom % 3; dw = $urandom % 3;
      si = $urandom % 2; di = $urandom % 2;
      cnt = 1 + $urandom % 16;
      ratio = (dw > sw) ? (1 << (dw - sw)) : 1;
      load_mem(0, 100 + t);
      if (ratio > 1 && ($urandom % 5) == 0) begin
        bad_case(mk_ctrl((cnt / ratio) * ratio + 1, sw, dw, si, di, 13'($urandom)), "R5");
      end else begin
        cnt = ((cnt + ratio - 1) / ratio) * ratio;
        legal_case(sw, dw, cnt, si, di, $urandom % 32, 128 + $urandom % 32, 13'($urandom), 0);
      end
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule